// File: doc/BRIEF.md
# Double-Buffered DAC Code Latch

This block is the digital front end of a parallel-input, segmented current-steering DAC. A parallel code word passes through two storage stages: an input stage written under an active-low write strobe, and a DAC stage that takes the input stage's contents while a load strobe is high. Both stages are flops clocked by the system clock, with the two strobes sampled as level enables. With the write strobe low and the load strobe high together, the bus reaches the DAC code in one clock. Several converters that share one load strobe can therefore update at the same moment.

An active-low reset clears both stages at once, without waiting for a clock, and is released in step with the clock. The value it loads is set by a select pin: all zeros (zero scale) or only the top bit set (midscale). The DAC stage output is split in two. Its four most significant bits become fifteen equally weighted thermometer segment enables, and the remaining bits drive the binary ladder switches directly. The word width is a parameter (16 by default, 14 as the alternative), and the midscale value and the segment/ladder split follow from it.

Top module: `dac_code_latch`

## Requirements
- R1: While `wr_ni` is 0, every clock edge loads `data_i` into the input register. While `wr_ni` is 1, the input register keeps its value.
- R2: While `ldac_i` is 1, the DAC register (`code_o`) takes the input register's value at the clock edge. While `ldac_i` is 0, `code_o` does not change.
- R3: With `wr_ni` = 0 and `ldac_i` = 1, `code_o` equals the `data_i` that was present at the previous clock edge (transparent path). With `wr_ni` = 1 and `ldac_i` = 0, no register changes.
- R4: When `wr_ni` and `ldac_i` carry one shared pulse, the low phase captures the bus into the input register and leaves `code_o` unchanged. The following high phase moves that captured word to `code_o` and ignores the bus.
- R5: `rst_ni` = 0 forces `code_o` at once, with no clock edge, to 0 when `mid_sel_i` = 0, and to a word with only bit W-1 set when `mid_sel_i` = 1. It overrides both strobes. After release, the strobes act from the third rising clock edge onward.
- R6: Segment enable `seg_en_o[k-1]` (k = 1..15) is 1 exactly when the unsigned value of `code_o[W-1:W-4]` is k or greater.
- R7: `ladder_o` equals `code_o[W-5:0]`. Bit 0 is the LSB, in straight binary order.
- R8: Reset also clears the input register to the same reset value. A load with `ldac_i` = 1 and `wr_ni` = 1 after reset therefore leaves `code_o` at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| mid_sel_i | input | 1 | Reset value select: 0 gives zero scale, 1 gives midscale |
| wr_ni | input | 1 | Active-low write enable for the input register |
| ldac_i | input | 1 | Active-high load enable for the DAC register |
| data_i | input | W | Parallel code word |
| code_o | output | W | DAC register contents |
| seg_en_o | output | 15 | Thermometer segment enables |
| ladder_o | output | W-4 | Binary ladder switch drives |

## Verification
Reset and the strobes can land in the same cycle. The bench pulls `rst_ni` low while `wr_ni` is 0 and `ldac_i` is 1 with a new word on the bus. It checks `code_o` before any clock edge and again after several edges: only the reset value, chosen by `mid_sel_i`, may appear. It then releases reset with the strobes still active and checks that the bus word reaches `code_o` no earlier than the third edge. The segment decode is judged against a bench thermometer function at every check point, including a sweep over all sixteen top-nibble values.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  localparam int unsigned SEG_BITS = 4;
  localparam int unsigned SEG_CNT  = (1 << SEG_BITS) - 1;

  typedef enum logic [1:0] {
    CTL_HOLD   = 2'b10,  // wr_n=1, ldac=0
    CTL_WRITE  = 2'b00,  // wr_n=0, ldac=0
    CTL_LOAD   = 2'b11,  // wr_n=1, ldac=1
    CTL_THRU   = 2'b01   // wr_n=0, ldac=1
  } ctl_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dac_dbl_reg.sv
module dac_dbl_reg
  import dac_latch_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mid_sel_i,
  input  logic         wr_ni,
  input  logic         ldac_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] in_q_o,
  output logic [W-1:0] dac_q_o
);
  localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

  ctl_e         ctl;
  logic [W-1:0] rst_code;
  logic [W-1:0] in_d, dac_d;
  logic [W-1:0] in_q, dac_q;

  assign ctl      = ctl_e'({wr_ni, ldac_i});
  assign rst_code = mid_sel_i ? MID_CODE : '0;

  always_comb begin
    in_d  = in_q;
    dac_d = dac_q;
    unique case (ctl)
      CTL_WRITE: in_d = data_i;
      CTL_LOAD:  dac_d = in_q;
      CTL_THRU: begin
        in_d  = data_i;
        dac_d = data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= rst_code;
      dac_q <= rst_code;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
    end
  end

  assign in_q_o  = in_q;
  assign dac_q_o = dac_q;
endmodule

// File: rtl/dac_seg_decode.sv
module dac_seg_decode
  import dac_latch_pkg::*;
(
  input  logic [SEG_BITS-1:0] msb_i,
  output logic [SEG_CNT-1:0]  seg_en_o
);
  for (genvar k = 1; k <= SEG_CNT; k++) begin : g_seg
    assign seg_en_o[k-1] = (msb_i >= SEG_BITS'(k));
  end
endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
  import dac_latch_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mid_sel_i,
  input  logic                 wr_ni,
  input  logic                 ldac_i,
  input  logic [W-1:0]         data_i,
  output logic [W-1:0]         code_o,
  output logic [SEG_CNT-1:0]   seg_en_o,
  output logic [W-SEG_BITS-1:0] ladder_o
);
  localparam int unsigned LAD_W = W - SEG_BITS;

  logic         rst_sync_n;
  logic [W-1:0] in_code_q;
  logic [W-1:0] dac_code_q;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dac_dbl_reg #(.W(W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .mid_sel_i (mid_sel_i),
    .wr_ni     (wr_ni),
    .ldac_i    (ldac_i),
    .data_i    (data_i),
    .in_q_o    (in_code_q),
    .dac_q_o   (dac_code_q)
  );

  dac_seg_decode u_seg (
    .msb_i    (dac_code_q[W-1:LAD_W]),
    .seg_en_o (seg_en_o)
  );

  assign code_o   = dac_code_q;
  assign ladder_o = dac_code_q[LAD_W-1:0];
endmodule

// File: rtl/dac_code_latch_chk.sv
module dac_code_latch_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rst_sync_n,
  input logic         mid_sel_i,
  input logic         wr_ni,
  input logic         ldac_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] in_code_q,
  input logic [W-1:0] code_o,
  input logic [14:0]  seg_en_o,
  input logic [W-5:0] ladder_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  p_wr_load_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !wr_ni |=> in_code_q == $past(data_i));
  p_wr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wr_ni |=> $stable(in_code_q));
  p_ldac_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !ldac_i |=> $stable(code_o));
  p_ldac_load_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ldac_i && wr_ni) |=> code_o == $past(in_code_q));
  p_thru_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ldac_i && !wr_ni) |=> code_o == $past(data_i));
  p_rst_value_r5: assert property (@(posedge clk_i)
    !rst_ni |-> code_o == (mid_sel_i ? MID : '0));
  p_rst_input_r8: assert property (@(posedge clk_i)
    !rst_ni |-> in_code_q == (mid_sel_i ? MID : '0));
  p_seg_count_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $countones(seg_en_o) == 32'(code_o[W-1:W-4]));
  p_seg_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (seg_en_o & (seg_en_o + 15'd1)) == 15'd0);
  p_ladder_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ladder_o == code_o[W-5:0]);
endmodule

bind dac_code_latch dac_code_latch_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_n (rst_sync_n),
  .mid_sel_i  (mid_sel_i),
  .wr_ni      (wr_ni),
  .ldac_i     (ldac_i),
  .data_i     (data_i),
  .in_code_q  (in_code_q),
  .code_o     (code_o),
  .seg_en_o   (seg_en_o),
  .ladder_o   (ladder_o)
);

// File: tb/dac_code_latch_tb_top.sv
module dac_code_latch_tb_top;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] MID = 16'h8000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mid_sel = 1'b0;
  logic          wr_n = 1'b1;
  logic          ldac = 1'b0;
  logic [W-1:0]  data = '0;
  logic [W-1:0]  code;
  logic [14:0]   seg;
  logic [W-5:0]  ladder;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] in_m, dac_m;

  always #10 clk = ~clk;

  dac_code_latch #(.W(W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mid_sel_i (mid_sel),
    .wr_ni     (wr_n),
    .ldac_i    (ldac),
    .data_i    (data),
    .code_o    (code),
    .seg_en_o  (seg),
    .ladder_o  (ladder)
  );

  function automatic logic [14:0] exp_seg(input logic [W-1:0] c);
    logic [14:0] s;
    for (int k = 1; k <= 15; k++) s[k-1] = (c[W-1:W-4] >= 4'(k));
    return s;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] exp);
    checks++;
    if (code !== exp) begin
      fails++;
      $display("FAIL %s code act=%h exp=%h", req, code, exp);
    end
    checks++;
    if (seg !== exp_seg(exp)) begin
      fails++;
      $display("FAIL %s seg act=%h exp=%h", req, seg, exp_seg(exp));
    end
    checks++;
    if (ladder !== exp[W-5:0]) begin
      fails++;
      $display("FAIL %s ladder act=%h exp=%h", req, ladder, exp[W-5:0]);
    end
  endtask

  // one clock with given strobes; model follows the requirements
  task automatic step(input logic w, input logic l, input logic [W-1:0] d);
    @(negedge clk);
    wr_n = w; ldac = l; data = d;
    @(posedge clk);
    if (l) dac_m = !w ? d : in_m;
    if (!w) in_m = d;
    #1;
  endtask

  task automatic do_reset(input logic mid);
    @(negedge clk);
    mid_sel = mid;
    rst_n = 1'b0;
    in_m = mid ? MID : '0;
    dac_m = in_m;
    #1;
    chk("R5 async", dac_m);
    repeat (3) @(posedge clk);
    #1;
    chk("R5 held", dac_m);
    @(negedge clk);
    wr_n = 1'b1; ldac = 1'b0;
    rst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0, '0);
  endtask

  initial begin : watchdog
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    in_m = '0; dac_m = '0;
    #1;
    chk("R5 zero at start", 16'h0000);
    do_reset(1'b0);
    chk("R5 zero scale", 16'h0000);

    // R8: reset cleared input register too
    step(1'b1, 1'b1, 16'hFFFF);
    chk("R8 load after zero reset", 16'h0000);

    do_reset(1'b1);
    chk("R5 midscale", MID);
    step(1'b1, 1'b1, 16'h1234);
    chk("R8 load after mid reset", MID);

    // truth table rows
    step(1'b0, 1'b0, 16'hA5C3);
    chk("R1 write no load", MID);
    step(1'b1, 1'b0, 16'h0F0F);
    chk("R3 hold row", MID);
    step(1'b1, 1'b1, 16'h7777);
    chk("R2 load from input R1 hold", 16'hA5C3);
    step(1'b0, 1'b1, 16'h3C5A);
    chk("R3 transparent", 16'h3C5A);
    step(1'b1, 1'b0, 16'hFFFF);
    chk("R2 ldac low holds", 16'h3C5A);

    // R4 tied pulse
    step(1'b0, 1'b0, 16'hBEEF);
    chk("R4 low phase", 16'h3C5A);
    step(1'b1, 1'b1, 16'h1111);
    chk("R4 high phase", 16'hBEEF);
    step(1'b1, 1'b1, 16'h2222);
    chk("R4 bus ignored", 16'hBEEF);

    // R6 R7 sweep of top nibble
    for (int m = 0; m < 16; m++) begin
      logic [W-1:0] d;
      d = {4'(m), 12'($urandom)};
      step(1'b0, 1'b1, d);
      chk("R6 R7 nibble sweep", d);
    end

    // R5 reset colliding with active strobes
    @(negedge clk);
    wr_n = 1'b0; ldac = 1'b1; data = 16'h4321;
    mid_sel = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R5 overrides strobes async", 16'h0000);
    repeat (2) @(posedge clk);
    #1;
    chk("R5 overrides strobes clocked", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R5 release edge1", 16'h0000);
    @(posedge clk); #1;
    chk("R5 release edge2", 16'h0000);
    @(posedge clk); #1;
    chk("R5 release edge3", 16'h4321);
    in_m = 16'h4321; dac_m = 16'h4321;

    // random mix R1 R2 R3
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      c = 2'($urandom);
      step(c[1], c[0], 16'($urandom));
      chk("R1 R2 R3 random", dac_m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule